// File: doc/BRIEF.md
# Mode-Banked Register File

A 32-bit register file for a processor core in which the register a program sees depends on the current operating mode as well as on the register index. Sixteen indices are visible at a time: indices 13 and 14 act as stack pointer and link register, and index 15 holds the program counter. The fast-interrupt mode gets private copies of indices 8 to 14. The normal-interrupt, supervisor, abort and undefined modes each get only private copies of 13 and 14. The unprivileged mode and the system mode see the same base set.

Each of the five exception modes also owns one saved-status word, which is read and written through a separate port. The file has 31 general physical words (the program counter included) and 5 saved-status words. It offers two combinational read ports and one write port. Writes land on the next rising clock edge, so a read in the same cycle as a write returns the old value.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset, active high, clears every general word and every saved-status word to zero.
- R2: The mode input decodes as follows: 10000 unprivileged, 10001 fast interrupt, 10010 normal interrupt, 10011 supervisor, 10111 abort, 11011 undefined, 11111 system. Any other value selects the unprivileged bank.
- R3: Indices 0 to 7 and index 15 (program counter) name the same physical words in every mode.
- R4: In fast-interrupt mode, indices 8 to 14 name words private to that mode. These words are invisible to all other modes.
- R5: Normal-interrupt, supervisor, abort and undefined modes each own private words for indices 13 and 14. They share indices 8 to 12 with the unprivileged bank.
- R6: System mode reads and writes exactly the unprivileged bank.
- R7: Each of the five exception modes has its own saved-status word. A write in one exception mode changes only that mode's word.
- R8: In unprivileged or system mode, the saved-status read returns zero and a saved-status write changes no stored word.
- R9: A write and a read of the same physical word in one cycle return the old value on the read port. The new value appears after the clock edge.
- R10: Both read ports select independently among all sixteen indices, and the write port can write any index, including 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 5 | Current operating mode |
| ra_idx | input | 4 | Read port A index |
| rb_idx | input | 4 | Read port B index |
| rd_a | output | 32 | Read port A data |
| rd_b | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write index |
| wr_data | input | 32 | Write data |
| sv_wr_en | input | 1 | Saved-status write enable |
| sv_wr_data | input | 32 | Saved-status write data |
| sv_rd_data | output | 32 | Saved-status word of the current mode |

## Verification
The hardest case to reach is aliasing: proving that a word written in one mode is, or is not, visible through the same index in another mode. The ports show only the current mode's view, so the stimulus has to write in one mode, switch modes, and read back. The stimulus first fills the unprivileged bank and then writes tagged values into every private bank. It then sweeps all sixteen indices in every legal mode and in one undefined encoding. A long random phase follows that mixes mode changes with same-cycle writes. A behavioural model keyed by bank name is compared against all three outputs before every clock edge.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    mode,
  input  logic [AW-1:0] ra_idx,
  input  logic [AW-1:0] rb_idx,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          sv_wr_en,
  input  logic [DW-1:0] sv_wr_data,
  output logic [DW-1:0] sv_rd_data
);
  localparam int NREG      = 1 << AW;
  localparam int NFIQ      = 7;
  localparam int NPAIR     = 4;
  localparam int FIQ_BASE  = NREG;
  localparam int PAIR_BASE = NREG + NFIQ;
  localparam int NPHYS     = PAIR_BASE + 2 * NPAIR;
  localparam int NSV       = NPAIR + 1;
  localparam int PW        = $clog2(NPHYS);

  typedef enum logic [2:0] {B_USR, B_FIQ, B_IRQ, B_SVC, B_ABT, B_UND} bank_t;

  logic [DW-1:0] rf [NPHYS];
  logic [DW-1:0] sv [NSV];
  bank_t         bank;
  logic [2:0]    sidx;
  logic          priv;

  always_comb begin
    case (mode)
      5'b10001: bank = B_FIQ;
      5'b10010: bank = B_IRQ;
      5'b10011: bank = B_SVC;
      5'b10111: bank = B_ABT;
      5'b11011: bank = B_UND;
      default:  bank = B_USR;
    endcase
  end

  function automatic logic [PW-1:0] phys(bank_t b, logic [AW-1:0] i);
    int n;
    n = int'(i);
    if (b == B_FIQ && n >= 8 && n <= 14)
      return PW'(FIQ_BASE + n - 8);
    if (b != B_USR && b != B_FIQ && (n == 13 || n == 14))
      return PW'(PAIR_BASE + 2 * (int'(b) - 2) + n - 13);
    return PW'(n);
  endfunction

  assign priv       = (bank != B_USR);
  assign sidx       = priv ? 3'(bank) - 3'd1 : 3'd0;
  assign rd_a       = rf[phys(bank, ra_idx)];
  assign rd_b       = rf[phys(bank, rb_idx)];
  assign sv_rd_data = priv ? sv[sidx] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NPHYS; k++) rf[k] <= '0;
      for (int k = 0; k < NSV; k++) sv[k] <= '0;
    end else begin
      if (wr_en) rf[phys(bank, wr_idx)] <= wr_data;
      if (sv_wr_en && priv) sv[sidx] <= sv_wr_data;
    end
  end
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [4:0]    mode,
  input logic [AW-1:0] ra_idx,
  input logic [AW-1:0] rb_idx,
  input logic [DW-1:0] rd_a,
  input logic [DW-1:0] rd_b,
  input logic          wr_en,
  input logic [AW-1:0] wr_idx,
  input logic [DW-1:0] wr_data,
  input logic          sv_wr_en,
  input logic [DW-1:0] sv_wr_data,
  input logic [DW-1:0] sv_rd_data
);
  logic user_view;
  logic exc_mode;
  assign user_view = (mode == 5'b10000) || (mode == 5'b11111);
  assign exc_mode  = (mode == 5'b10001) || (mode == 5'b10010) || (mode == 5'b10011)
                  || (mode == 5'b10111) || (mode == 5'b11011);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_a == '0 && rd_b == '0 && sv_rd_data == '0));

  assert_shared_low_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $stable(ra_idx) && (int'(ra_idx) < 8 || int'(ra_idx) == 15))
      |-> $stable(rd_a));

  assert_no_saved_user_R8: assert property (@(posedge clk) disable iff (rst)
    user_view |-> sv_rd_data == '0);

  assert_saved_write_R7: assert property (@(posedge clk) disable iff (rst)
    (sv_wr_en && exc_mode) |=> (mode != $past(mode) || sv_rd_data == $past(sv_wr_data)));

  assert_write_next_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (mode != $past(mode) || ra_idx != $past(wr_idx) || rd_a == $past(wr_data)));

  assert_ports_agree_R10: assert property (@(posedge clk) disable iff (rst)
    (ra_idx == rb_idx) |-> rd_a == rd_b);
endmodule

bind banked_regfile banked_regfile_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .ra_idx(ra_idx), .rb_idx(rb_idx),
  .rd_a(rd_a), .rd_b(rd_b), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .sv_wr_en(sv_wr_en), .sv_wr_data(sv_wr_data), .sv_rd_data(sv_rd_data)
);

// File: tb/tb_banked_regfile.sv
`timescale 1ns/1ps
module tb_banked_regfile;
  logic        clk = 0;
  logic        rst = 1;
  logic [4:0]  mode = 5'b10000;
  logic [3:0]  ra_idx = 0, rb_idx = 0, wr_idx = 0;
  logic [31:0] rd_a, rd_b, sv_rd_data, wr_data = 0, sv_wr_data = 0;
  logic        wr_en = 0, sv_wr_en = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  banked_regfile dut (.clk(clk), .rst(rst), .mode(mode), .ra_idx(ra_idx), .rb_idx(rb_idx),
    .rd_a(rd_a), .rd_b(rd_b), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sv_wr_en(sv_wr_en), .sv_wr_data(sv_wr_data), .sv_rd_data(sv_rd_data));

  logic [31:0] m_reg [string];
  logic [31:0] m_sv  [string];
  localparam logic [4:0] MODES [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                       5'b10111, 5'b11011, 5'b11111, 5'b10100};

  function automatic string owner(logic [4:0] m, int i);
    string p;
    case (m)
      5'b10001: p = "fiq";
      5'b10010: p = "irq";
      5'b10011: p = "svc";
      5'b10111: p = "abt";
      5'b11011: p = "und";
      default:  p = "";
    endcase
    if (p == "fiq" && i >= 8 && i <= 14) return $sformatf("fiq_%0d", i);
    if (p != "" && p != "fiq" && (i == 13 || i == 14)) return $sformatf("%s_%0d", p, i);
    return $sformatf("usr_%0d", i);
  endfunction

  function automatic string sv_owner(logic [4:0] m);
    case (m)
      5'b10001: return "fiq";
      5'b10010: return "irq";
      5'b10011: return "svc";
      5'b10111: return "abt";
      5'b11011: return "und";
      default:  return "";
    endcase
  endfunction

  function automatic logic [31:0] m_read(logic [4:0] m, int i);
    string k = owner(m, i);
    return m_reg.exists(k) ? m_reg[k] : 32'h0;
  endfunction

  function automatic logic [31:0] m_sv_read(logic [4:0] m);
    string k = sv_owner(m);
    if (k == "") return 32'h0;
    return m_sv.exists(k) ? m_sv[k] : 32'h0;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h mode=%b", tag, what, act, exp, mode);
    end
  endtask

  task automatic cyc(string tag, logic [4:0] m, int a, int b,
                     bit we, int wi, logic [31:0] wd, bit swe, logic [31:0] swd);
    mode = m; ra_idx = 4'(a); rb_idx = 4'(b);
    wr_en = we; wr_idx = 4'(wi); wr_data = wd;
    sv_wr_en = swe; sv_wr_data = swd;
    #1;
    check(tag, "rd_a", rd_a, m_read(m, a));
    check(tag, "rd_b", rd_b, m_read(m, b));
    check(tag, "sv_rd", sv_rd_data, m_sv_read(m));
    @(posedge clk);
    if (we) m_reg[owner(m, wi)] = wd;
    if (swe && sv_owner(m) != "") m_sv[sv_owner(m)] = swd;
    @(negedge clk);
  endtask

  task automatic sweep(string tag, logic [4:0] m);
    for (int i = 0; i < 16; i += 2) cyc(tag, m, i, i + 1, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    mode = 5'b10011; wr_en = 1; wr_idx = 4'd13; wr_data = 32'hDEAD; sv_wr_en = 1; sv_wr_data = 32'hBEEF;
    @(negedge clk); @(negedge clk);
    rst = 0; wr_en = 0; sv_wr_en = 0;
    foreach (MODES[j]) sweep("R1", MODES[j]);

    for (int i = 0; i < 16; i++) cyc("R10", 5'b10000, i, 15 - i, 1, i, 32'h1000_0000 + i, 0, 0);
    sweep("R10", 5'b10000);

    for (int i = 8; i < 15; i++) cyc("R4", 5'b10001, i, i, 1, i, 32'hF100_0000 + i, 0, 0);
    sweep("R4", 5'b10001);
    sweep("R4", 5'b10000);

    for (int j = 2; j < 6; j++) begin
      cyc("R5", MODES[j], 13, 14, 1, 13, 32'h5000_0000 + j, 0, 0);
      cyc("R5", MODES[j], 13, 14, 1, 14, 32'h5100_0000 + j, 0, 0);
    end
    cyc("R5", 5'b10011, 9, 12, 1, 10, 32'h5A5A_0010, 0, 0);
    for (int j = 0; j < 6; j++) sweep("R5", MODES[j]);

    cyc("R6", 5'b11111, 13, 9, 1, 14, 32'h6666_0014, 0, 0);
    sweep("R6", 5'b11111);
    sweep("R6", 5'b10000);

    cyc("R2", 5'b10100, 13, 14, 1, 13, 32'h2222_0013, 0, 0);
    sweep("R2", 5'b10100);
    sweep("R2", 5'b10000);
    sweep("R2", 5'b10001);

    for (int j = 1; j < 6; j++) cyc("R7", MODES[j], 0, 1, 0, 0, 0, 1, 32'h7700_0000 + j);
    for (int j = 0; j < 8; j++) cyc("R7", MODES[j], 0, 1, 0, 0, 0, 0, 0);

    cyc("R8", 5'b10000, 0, 1, 0, 0, 0, 1, 32'h8888_8888);
    cyc("R8", 5'b11111, 0, 1, 0, 0, 0, 1, 32'h8888_9999);
    for (int j = 0; j < 8; j++) cyc("R8", MODES[j], 0, 1, 0, 0, 0, 0, 0);

    for (int j = 0; j < 8; j++) begin
      cyc("R3", MODES[j], j, 15, 1, j, 32'h3300_0000 + j, 0, 0);
      for (int k = 0; k < 8; k++) cyc("R3", MODES[k], j, 15, 0, 0, 0, 0, 0);
    end

    cyc("R9", 5'b10001, 9, 9, 1, 9, 32'h9999_0009, 0, 0);
    cyc("R9", 5'b10001, 9, 9, 0, 0, 0, 0, 0);
    cyc("R9", 5'b10010, 14, 14, 1, 14, 32'h9999_0014, 0, 0);
    cyc("R9", 5'b10010, 14, 14, 0, 0, 0, 0, 0);

    for (int n = 0; n < 3000; n++) begin
      logic [4:0] m = MODES[$urandom_range(0, 7)];
      cyc("R9", m, int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
          bit'($urandom_range(0, 1)), int'($urandom_range(0, 15)), $urandom,
          ($urandom_range(0, 3) == 0), $urandom);
    end
    finish_run();
  end
endmodule